// File: doc/BRIEF.md
# Two-Wire Write Slave with High-Speed Entry and General-Call Reset

This block is the receive front end of a two-wire serial slave. A fast system clock oversamples the bus clock and data lines. The block finds START, repeated START and STOP conditions and compares the first byte of each transfer with its own 7-bit address. The lowest address bit comes from a strap pin. When the address matches and the transfer is a write, the block acknowledges every data byte and hands each one to downstream logic as an 8-bit value with a one-cycle valid strobe. The block never drives the clock line. It takes part in the data line only through an open-drain pull-low enable.

Two other first-byte patterns have their own handling. A high-speed master code is never acknowledged. It raises a mode flag that stays set across repeated STARTs and is cleared by the next STOP. A general-call address followed by the reset command byte is acknowledged and produces a one-cycle reset pulse.

Top module: `twowire_hs_slave`

## Requirements
- R1: A START (data falls while clock is high) begins address reception, and a STOP (data rises while clock is high) returns the block to idle. After a STOP, bits clocked without a new START are not acknowledged.
- R2: Bits are sampled on the rising bus clock edge, most significant bit first. Bit 0 of the first byte is the direction flag, with 0 meaning write.
- R3: The slave address is binary 111010 followed by the strap pin level: 0x74 with the strap low and 0x75 with the strap high. A first byte of 0xE8 matches only when the strap is low, and 0xEA matches only when it is high.
- R4: A matching address byte is acknowledged on the ninth clock by pulling data low. If its direction flag is 1, the block goes idle after the acknowledge and does not acknowledge later bytes of that transfer.
- R5: In a matched write, every data byte is acknowledged. At the start of its acknowledge bit it appears on `wr_data_o` together with a `wr_valid_o` pulse that lasts one clock.
- R6: A first byte that is neither the slave address, 0x00, nor a master code is not acknowledged. The block then ignores the bus until the next START.
- R7: A first byte of binary 00001xxx, for any xxx, is a master code. It is never acknowledged and it sets `hs_mode_o`.
- R8: `hs_mode_o` stays set across repeated STARTs and is cleared by a STOP.
- R9: A first byte of 0x00 is acknowledged. If the next byte is 0x06, that byte is acknowledged and `gc_reset_o` pulses for one clock. Any other second byte is not acknowledged, produces no pulse and produces no `wr_valid_o`.
- R10: A repeated START in the middle of a byte discards the partial byte, produces no `wr_valid_o`, and restarts address reception.
- R11: `sda_pull_o` is released one system clock after the detected clock falling edge that ends an acknowledge bit.
- R12: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_strap_i | input | 1 | Address bit 0 strap |
| sda_pull_o | output | 1 | High when the data line is to be pulled low |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_data_o | output | 8 | Received write byte |
| hs_mode_o | output | 1 | High-speed mode flag |
| gc_reset_o | output | 1 | One-cycle general-call reset pulse |

## Verification
The assertions assume that the clock line and the data line never change in the same system-clock sample. They also assume that each bus clock phase lasts several system clocks, so that the pull enable, the strobe and the reset pulse have settled long before the next edge. The bench meets both assumptions by holding each quarter of a bus bit for eight system clocks and by changing the data line only at mid-low of the bus clock, or at mid-high when it forms a START or STOP. The bench also never drives data low while the slave is expected to release the line in a way that would create a false condition.

// File: rtl/tw_pkg.sv
// Shared constants and types for the two-wire write slave.
// Assumes 8-bit bytes and a 7-bit address with a strap-selected low bit.
package tw_pkg;
    localparam int BYTE_W = 8;
    localparam logic [5:0] ADDR_HI   = 6'b111010;
    localparam logic [4:0] MCODE_HI  = 5'b00001;
    localparam logic [7:0] GC_ADDR   = 8'h00;
    localparam logic [7:0] GC_RST    = 8'h06;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_ACK  = 2'd2,
        ST_DATA = 2'd3
    } tw_state_t;
endpackage

// File: rtl/tw_sync.sv
// Synchroniser and edge/condition detector for the bus lines.
// Assumes both lines idle high; the flops reset to 1 so reset creates no edge.
module tw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_prev;
    logic              sda_prev;

    // First stage samples the raw lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q[0] <= 1'b1;
            sda_q[0] <= 1'b1;
        end else begin
            scl_q[0] <= scl_i;
            sda_q[0] <= sda_i;
        end
    end

    // Remaining synchroniser stages, one per generate iteration.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                scl_q[g] <= 1'b1;
                sda_q[g] <= 1'b1;
            end else begin
                scl_q[g] <= scl_q[g-1];
                sda_q[g] <= sda_q[g-1];
            end
        end
    end

    // Previous-sample register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_q[STAGES-1];
            sda_prev <= sda_q[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronised levels.
    always_comb begin
        sda_s     = sda_q[STAGES-1];
        scl_rise  = scl_q[STAGES-1] & ~scl_prev;
        scl_fall  = ~scl_q[STAGES-1] & scl_prev;
        start_det = scl_q[STAGES-1] & scl_prev & sda_prev & ~sda_q[STAGES-1];
        stop_det  = scl_q[STAGES-1] & scl_prev & ~sda_prev & sda_q[STAGES-1];
    end
endmodule

// File: rtl/tw_shift.sv
// Bit collector: shifts data in MSB first on each clock rise while enabled.
// Assumes the controller clears it at every condition and after each byte.
module tw_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    input  logic            scl_rise,
    input  logic            sda_s,
    output logic [BITS-1:0] data,
    output logic            full
);
    localparam int CW = $clog2(BITS + 1);
    logic [CW-1:0] cnt;

    // Shift register and bit count; clear wins over shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            cnt  <= '0;
        end else if (clr) begin
            cnt  <= '0;
        end else if (en && scl_rise && !full) begin
            data <= {data[BITS-2:0], sda_s};
            cnt  <= cnt + 1'b1;
        end
    end

    // Byte complete flag.
    always_comb full = (cnt == CW'(BITS));
endmodule

// File: rtl/tw_fsm.sv
// Transfer controller: decodes first byte, acknowledges, emits bytes,
// tracks high-speed mode and the general-call reset.
// Assumes bus clock phases span several system clocks.
module tw_fsm
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_full,
    output logic              shift_en,
    output logic              shift_clr,
    output logic              pull,
    output logic              valid,
    output logic [BYTE_W-1:0] data_out,
    output logic              hs,
    output logic              gc_pulse
);
    tw_state_t state;
    tw_state_t ack_next;
    logic      gc_mode;
    logic      byte_end;

    // Byte boundary and shifter control.
    always_comb begin
        shift_en  = (state == ST_ADDR) || (state == ST_DATA);
        byte_end  = shift_en && scl_fall && rx_full;
        shift_clr = start_det || stop_det || byte_end;
    end

    // Main controller state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ack_next <= ST_IDLE;
            gc_mode  <= 1'b0;
            pull     <= 1'b0;
            valid    <= 1'b0;
            data_out <= '0;
            hs       <= 1'b0;
            gc_pulse <= 1'b0;
        end else begin
            valid    <= 1'b0;
            gc_pulse <= 1'b0;
            if (stop_det) begin
                state   <= ST_IDLE;
                pull    <= 1'b0;
                hs      <= 1'b0;
                gc_mode <= 1'b0;
            end else if (start_det) begin
                state   <= ST_ADDR;
                pull    <= 1'b0;
                gc_mode <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: if (byte_end) begin
                        if (rx_byte[7:1] == {ADDR_HI, strap}) begin
                            pull     <= 1'b1;
                            state    <= ST_ACK;
                            ack_next <= rx_byte[0] ? ST_IDLE : ST_DATA;
                        end else if (rx_byte == GC_ADDR) begin
                            pull     <= 1'b1;
                            gc_mode  <= 1'b1;
                            state    <= ST_ACK;
                            ack_next <= ST_DATA;
                        end else if (rx_byte[7:3] == MCODE_HI) begin
                            hs    <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_DATA: if (byte_end) begin
                        if (gc_mode) begin
                            if (rx_byte == GC_RST) begin
                                pull     <= 1'b1;
                                gc_pulse <= 1'b1;
                                state    <= ST_ACK;
                                ack_next <= ST_IDLE;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            pull     <= 1'b1;
                            valid    <= 1'b1;
                            data_out <= rx_byte;
                            state    <= ST_ACK;
                            ack_next <= ST_DATA;
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        pull  <= 1'b0;
                        state <= ack_next;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_ADDR)); // R1
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && scl_fall && !start_det && !stop_det) |=> !pull); // R11
    AST_STOP_CLEARS_HS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hs); // R8
    AST_MCODE_NOACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs) |-> !pull); // R7
    AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R5
    AST_VALID_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pull); // R5
    AST_GC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        gc_pulse |=> !gc_pulse); // R9
endmodule

// File: rtl/twowire_hs_slave.sv
// Top of the two-wire write slave: synchroniser, bit collector, controller.
// Assumes the system clock runs at least 16x the bus clock; never drives SCL.
module twowire_hs_slave
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_strap_i,
    output logic              sda_pull_o,
    output logic              wr_valid_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              hs_mode_o,
    output logic              gc_reset_o
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              shift_en, shift_clr, rx_full;
    logic [BYTE_W-1:0] rx_byte;

    tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tw_shift #(.BITS(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(shift_en), .clr(shift_clr),
        .scl_rise(scl_rise), .sda_s(sda_s), .data(rx_byte), .full(rx_full)
    );

    tw_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strap(addr_strap_i), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .rx_byte(rx_byte),
        .rx_full(rx_full), .shift_en(shift_en), .shift_clr(shift_clr),
        .pull(sda_pull_o), .valid(wr_valid_o), .data_out(wr_data_o),
        .hs(hs_mode_o), .gc_pulse(gc_reset_o)
    );
endmodule

// File: tb/tb_twowire_hs_slave.sv
module tb_twowire_hs_slave;
    localparam int Q = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
    logic sda_pull, wr_valid, hs_mode, gc_rst;
    logic [7:0] wr_data;
    logic sda_line;
    int n_run = 0, n_fail = 0, gc_count = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    twowire_hs_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_strap_i(strap), .sda_pull_o(sda_pull), .wr_valid_o(wr_valid),
        .wr_data_o(wr_data), .hs_mode_o(hs_mode), .gc_reset_o(gc_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bit_out(input logic b, output logic seen);
        sda_m = b; wq(); scl = 1'b1; wq(); seen = sda_line; wq(); scl = 1'b0; wq();
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i], s);
        bit_out(1'b1, s);
        ack = ~s;
    endtask

    task automatic put(input logic [7:0] b, input logic exp_ack, input string req);
        logic a;
        send(b, a);
        check(req, int'(a), int'(exp_ack));
    endtask

    task automatic put_data(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        put(b, 1'b1, req);
    endtask

    task automatic bus_start(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq(); endtask
    task automatic bus_stop();  sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); endtask

    // Scoreboard monitor: pops an expected byte for each strobe.
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R5 unexpected byte actual=%0h expected=none", wr_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (wr_data != e) begin
                    n_fail++;
                    $display("FAIL R5 byte actual=%0h expected=%0h", wr_data, e);
                end
            end
        end
        if (rst_n && gc_rst) gc_count++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic s;
        repeat (5) @(negedge clk);
        check("R12 pull", int'(sda_pull), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R12 outputs", int'({sda_pull, wr_valid, hs_mode, gc_rst}), 0);

        // R3 R4 R5 R2: matched write, strap low
        bus_start();
        put(8'hE8, 1'b1, "R3 addr 0x74 ack");
        check("R11 release after ack", int'(sda_pull), 0);
        put_data(8'hA5, "R5 data ack");
        put_data(8'h3C, "R2 data ack");
        bus_stop();
        // R1: bits without START after STOP are ignored
        put(8'hE8, 1'b0, "R1 no start no ack");
        check("R12 hs idle", int'(hs_mode), 0);

        // R3 strap high
        strap = 1'b1;
        bus_start(); put(8'hE8, 1'b0, "R3 0x74 nack strap high"); bus_stop();
        bus_start(); put(8'hEA, 1'b1, "R3 0x75 ack"); put_data(8'h5A, "R5 data strap high"); bus_stop();
        strap = 1'b0;

        // R6 wrong address
        bus_start(); put(8'h20, 1'b0, "R6 addr nack"); put(8'h11, 1'b0, "R6 data ignored"); bus_stop();

        // R4 read direction
        bus_start(); put(8'hE9, 1'b1, "R4 read addr ack"); put(8'h77, 1'b0, "R4 idle after read"); bus_stop();

        // R7 R8 master code
        bus_start(); put(8'h0D, 1'b0, "R7 master code nack");
        check("R7 hs set", int'(hs_mode), 1);
        bus_start(); put(8'hE8, 1'b1, "R8 addr in hs"); put_data(8'hC3, "R8 data in hs");
        check("R8 hs held", int'(hs_mode), 1);
        bus_start(); put(8'hE8, 1'b1, "R8 second rep start");
        check("R8 hs still held", int'(hs_mode), 1);
        bus_stop(); wq();
        check("R8 hs cleared", int'(hs_mode), 0);

        // R9 general call
        bus_start(); put(8'h00, 1'b1, "R9 gc addr ack"); put(8'h06, 1'b1, "R9 gc cmd ack"); bus_stop();
        check("R9 gc pulse count", gc_count, 1);
        bus_start(); put(8'h00, 1'b1, "R9 gc addr ack 2"); put(8'h05, 1'b0, "R9 other gc nack"); bus_stop();
        check("R9 no extra pulse", gc_count, 1);

        // R10 repeated START mid-byte
        bus_start(); put(8'hE8, 1'b1, "R10 addr");
        bit_out(1'b1, s); bit_out(1'b0, s); bit_out(1'b1, s); bit_out(1'b1, s);
        bus_start(); put(8'hE8, 1'b1, "R10 addr after abort");
        put_data(8'h99, "R10 byte after abort"); bus_stop();
        wq();
        check("R10 scoreboard empty", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule